// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit sits beside the decoder of an 8-bit accumulator processor with a 16-bit address space. When the decoder has identified the addressing mode of an instruction, it presents the mode, the address of the instruction itself, the two bytes that follow the opcode and the current index register. One clock later the unit returns the operand's effective address, the address of the following byte for 16-bit loads, an immediate data byte, and flags that say whether the instruction has no operand at all or whether an indexed offset was too wide for its encoding.

Eight modes are served. An instruction with no operand raises a flag and yields no address. An immediate instruction carries its data byte. An extended direct instruction carries a complete address. A branch adds a signed 8- or 16-bit displacement to its own address. An indexed access adds a signed 5-, 9- or 16-bit displacement to the index register. Every sum wraps modulo 65536. Opcode decode, memory cycles and arithmetic on data are left to other blocks.

Top module: `opaddr_gen`

## Requirements
- R1: While `rst_n` is low and after its release until the first strobe, every output is zero.
- R2: `res_valid` is high in the cycle after each cycle where `req_valid` is high and low after each cycle where it is low, so a single strobe gives a one-cycle pulse.
- R3: Mode 0 (no operand) sets `no_opnd` to 1 and sets `eff_addr`, `eff_addr_nx` and `imm_byte` to zero.
- R4: Mode 1 (immediate) sets `imm_byte` to `opnd_lo`, `eff_addr` and `eff_addr_nx` to zero and `no_opnd` to 0.
- R5: Mode 2 (extended direct) sets `eff_addr` to `{opnd_hi, opnd_lo}`, so any address from 0x0000 to 0xFFFF is reachable.
- R6: Mode 3 (short branch) sets `eff_addr` to `instr_addr` plus `opnd_lo` sign-extended, wrapping modulo 2^16 (0x0104 with 0xFC gives 0x0100).
- R7: Mode 4 (long branch) sets `eff_addr` to `instr_addr + {opnd_hi, opnd_lo}` modulo 2^16.
- R8: Modes 5, 6 and 7 (indexed with 5-, 9- and 16-bit displacement) set `eff_addr` to `idx_reg + {opnd_hi, opnd_lo}` modulo 2^16, the displacement read as a signed 16-bit value.
- R9: In mode 5 a displacement outside -16..15, and in mode 6 one outside -256..255, raises `ofs_err` and forces `eff_addr` and `eff_addr_nx` to zero; mode 7 and all other modes never raise it.
- R10: In modes 2 to 7 without `ofs_err`, `eff_addr_nx` equals `eff_addr + 1` modulo 2^16 (the high byte of a 16-bit load); otherwise it is zero.
- R11: While `req_valid` is low, all result outputs other than `res_valid` keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Strobe: inputs are taken in this cycle |
| mode | input | 3 | Addressing mode code, 0 to 7 as listed in the requirements |
| instr_addr | input | 16 | Address of the instruction being resolved |
| opnd_hi | input | 8 | First byte after the opcode (high byte of 16-bit fields) |
| opnd_lo | input | 8 | Second byte after the opcode (low byte, or the sole byte) |
| idx_reg | input | 16 | Current index register value |
| res_valid | output | 1 | One-cycle pulse: results below are fresh |
| eff_addr | output | 16 | Effective operand or target address |
| eff_addr_nx | output | 16 | Effective address plus one, for the high byte |
| imm_byte | output | 8 | Immediate operand byte |
| no_opnd | output | 1 | Instruction has no operand |
| ofs_err | output | 1 | Indexed displacement does not fit its width |

## Verification
The hardest situations to reach are the exact edges of the two short indexed widths: the extreme legal displacements (-16, 15, -256) must pass while the first values beyond them (16, 256, -257) must fail, and a wrong mask in the range check shows only there. The stimulus table places both sides of each edge next to each other, with the same index register, so a shifted bound changes one row's error flag and address. Wrap-around of every adder is reached by pairing bases near 0xFFFF with positive displacements and an extended address of 0xFFFF whose successor must roll to 0x0000.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    M_NONE  = 3'd0,
    M_IMM   = 3'd1,
    M_EXT   = 3'd2,
    M_BR8   = 3'd3,
    M_BR16  = 3'd4,
    M_IX5   = 3'd5,
    M_IX9   = 3'd6,
    M_IX16  = 3'd7
  } amode_t;

  // widen a byte to an address keeping its sign
  function automatic logic [ADDR_W-1:0] widen_signed(input logic [BYTE_W-1:0] b);
    return {{(ADDR_W-BYTE_W){b[BYTE_W-1]}}, b};
  endfunction

  // true when v, read as signed, is representable in w bits
  function automatic logic fits_signed(input logic [ADDR_W-1:0] v, input int unsigned w);
    logic [ADDR_W-1:0] top;
    top = {ADDR_W{1'b1}} << (w - 1);
    return ((v & top) == '0) || ((v & top) == top);
  endfunction

  function automatic logic [ADDR_W-1:0] wrap_add(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] b);
    return a + b;
  endfunction
endpackage

// File: rtl/opaddr_select.sv
module opaddr_select
  import opaddr_pkg::*;
#(
  parameter int unsigned IX_SHORT_W = 5,
  parameter int unsigned IX_MID_W   = 9
) (
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic [BYTE_W-1:0] opnd_hi,
  input  logic [BYTE_W-1:0] opnd_lo,
  input  logic [ADDR_W-1:0] idx_reg,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] disp,
  output logic              has_addr,
  output logic              none_flag,
  output logic              imm_flag,
  output logic              width_err
);
  logic [ADDR_W-1:0] word;
  assign word = {opnd_hi, opnd_lo};

  always_comb begin
    base      = '0;
    disp      = '0;
    has_addr  = 1'b0;
    none_flag = 1'b0;
    imm_flag  = 1'b0;
    width_err = 1'b0;
    unique case (amode_t'(mode))
      M_NONE: none_flag = 1'b1;
      M_IMM:  imm_flag  = 1'b1;
      M_EXT: begin
        disp     = word;
        has_addr = 1'b1;
      end
      M_BR8: begin
        base     = instr_addr;
        disp     = widen_signed(opnd_lo);
        has_addr = 1'b1;
      end
      M_BR16: begin
        base     = instr_addr;
        disp     = word;
        has_addr = 1'b1;
      end
      M_IX5: begin
        base      = idx_reg;
        disp      = word;
        has_addr  = 1'b1;
        width_err = !fits_signed(word, IX_SHORT_W);
      end
      M_IX9: begin
        base      = idx_reg;
        disp      = word;
        has_addr  = 1'b1;
        width_err = !fits_signed(word, IX_MID_W);
      end
      M_IX16: begin
        base     = idx_reg;
        disp     = word;
        has_addr = 1'b1;
      end
      default: none_flag = 1'b1;
    endcase
  end
endmodule

// File: rtl/opaddr_sum.sv
module opaddr_sum
  import opaddr_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] disp,
  output logic [ADDR_W-1:0] sum,
  output logic [ADDR_W-1:0] sum_nx
);
  assign sum    = wrap_add(base, disp);
  assign sum_nx = wrap_add(sum, {{(ADDR_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/opaddr_outreg.sv
module opaddr_outreg
  import opaddr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] sum,
  input  logic [ADDR_W-1:0] sum_nx,
  input  logic              has_addr,
  input  logic              none_flag,
  input  logic              imm_flag,
  input  logic              width_err,
  input  logic [BYTE_W-1:0] opnd_lo,
  output logic              res_valid,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] eff_addr_nx,
  output logic [BYTE_W-1:0] imm_byte,
  output logic              no_opnd,
  output logic              ofs_err
);
  logic addr_live;
  assign addr_live = has_addr && !width_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      eff_addr    <= '0;
      eff_addr_nx <= '0;
      imm_byte    <= '0;
      no_opnd     <= 1'b0;
      ofs_err     <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        eff_addr    <= addr_live ? sum : '0;
        eff_addr_nx <= addr_live ? sum_nx : '0;
        imm_byte    <= imm_flag ? opnd_lo : '0;
        no_opnd     <= none_flag;
        ofs_err     <= width_err;
      end
    end
  end

  p_pulse_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  p_pulse_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(eff_addr) && $stable(imm_byte) && $stable(ofs_err)));
  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_err |-> (eff_addr == '0 && eff_addr_nx == '0));
  p_none_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    no_opnd |-> (eff_addr == '0 && imm_byte == '0 && !ofs_err));
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import opaddr_pkg::*;
#(
  parameter int unsigned IX_SHORT_W = 5,
  parameter int unsigned IX_MID_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        mode,
  input  logic [15:0]       instr_addr,
  input  logic [7:0]        opnd_hi,
  input  logic [7:0]        opnd_lo,
  input  logic [15:0]       idx_reg,
  output logic              res_valid,
  output logic [15:0]       eff_addr,
  output logic [15:0]       eff_addr_nx,
  output logic [7:0]        imm_byte,
  output logic              no_opnd,
  output logic              ofs_err
);
  logic [ADDR_W-1:0] base_w, disp_w, sum_w, sum_nx_w;
  logic              has_addr_w, none_w, imm_w, werr_w;

  opaddr_select #(.IX_SHORT_W(IX_SHORT_W), .IX_MID_W(IX_MID_W)) u_sel (
    .mode(mode), .instr_addr(instr_addr), .opnd_hi(opnd_hi), .opnd_lo(opnd_lo),
    .idx_reg(idx_reg), .base(base_w), .disp(disp_w), .has_addr(has_addr_w),
    .none_flag(none_w), .imm_flag(imm_w), .width_err(werr_w)
  );

  opaddr_sum u_sum (
    .base(base_w), .disp(disp_w), .sum(sum_w), .sum_nx(sum_nx_w)
  );

  opaddr_outreg u_out (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .sum(sum_w), .sum_nx(sum_nx_w),
    .has_addr(has_addr_w), .none_flag(none_w), .imm_flag(imm_w), .width_err(werr_w),
    .opnd_lo(opnd_lo), .res_valid(res_valid), .eff_addr(eff_addr),
    .eff_addr_nx(eff_addr_nx), .imm_byte(imm_byte), .no_opnd(no_opnd), .ofs_err(ofs_err)
  );

  // width errors only arise for the two short indexed modes
  p_err_modes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    werr_w |-> (mode == M_IX5 || mode == M_IX9));
  // at most one of the mode class flags is active
  p_class_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({has_addr_w, none_w, imm_w}));
  // an extended address is passed through unchanged
  p_ext_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == M_EXT) |=> eff_addr == $past({opnd_hi, opnd_lo}));
endmodule

// File: tb/opaddr_gen_test.sv
module opaddr_gen_test;
  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  mode;
    logic [15:0] pc;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [15:0] x;
    logic [15:0] ea;
    logic        err;
    logic        none;
    logic [7:0]  imm;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{4'd3, 3'd0, 16'h0100, 8'hAB, 8'hCD, 16'h1234, 16'h0000, 1'b0, 1'b1, 8'h00}, // R3
    '{4'd4, 3'd1, 16'h0100, 8'h00, 8'h55, 16'h0000, 16'h0000, 1'b0, 1'b0, 8'h55}, // R4
    '{4'd5, 3'd2, 16'h0100, 8'h10, 8'h00, 16'h0000, 16'h1000, 1'b0, 1'b0, 8'h00}, // R5
    '{4'd5, 3'd2, 16'h0000, 8'hFF, 8'hFF, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 8'h00}, // R5 R10 wrap
    '{4'd6, 3'd3, 16'h0104, 8'h00, 8'hFC, 16'h0000, 16'h0100, 1'b0, 1'b0, 8'h00}, // R6
    '{4'd6, 3'd3, 16'hFFF0, 8'h99, 8'h20, 16'h0000, 16'h0010, 1'b0, 1'b0, 8'h00}, // R6 wrap
    '{4'd7, 3'd4, 16'h0100, 8'hFF, 8'h00, 16'h0000, 16'h0000, 1'b0, 1'b0, 8'h00}, // R7 wrap
    '{4'd8, 3'd7, 16'h0000, 8'h00, 8'h20, 16'h1000, 16'h1020, 1'b0, 1'b0, 8'h00}, // R8
    '{4'd8, 3'd7, 16'h0000, 8'h00, 8'h40, 16'h1000, 16'h1040, 1'b0, 1'b0, 8'h00}, // R8
    '{4'd8, 3'd5, 16'h0000, 8'hFF, 8'hF0, 16'h1000, 16'h0FF0, 1'b0, 1'b0, 8'h00}, // R8 -16
    '{4'd8, 3'd5, 16'h0000, 8'h00, 8'h0F, 16'h1000, 16'h100F, 1'b0, 1'b0, 8'h00}, // R8 +15
    '{4'd9, 3'd5, 16'h0000, 8'h00, 8'h10, 16'h1000, 16'h0000, 1'b1, 1'b0, 8'h00}, // R9 +16
    '{4'd8, 3'd6, 16'h0000, 8'hFF, 8'h00, 16'h1000, 16'h0F00, 1'b0, 1'b0, 8'h00}, // R8 -256
    '{4'd9, 3'd6, 16'h0000, 8'h01, 8'h00, 16'h1000, 16'h0000, 1'b1, 1'b0, 8'h00}, // R9 +256
    '{4'd9, 3'd6, 16'h0000, 8'hFE, 8'hFF, 16'h1000, 16'h0000, 1'b1, 1'b0, 8'h00}, // R9 -257
    '{4'd8, 3'd7, 16'h0000, 8'h00, 8'h01, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 8'h00}  // R8 wrap
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] instr_addr = '0;
  logic [7:0]  opnd_hi = '0;
  logic [7:0]  opnd_lo = '0;
  logic [15:0] idx_reg = '0;
  logic        res_valid;
  logic [15:0] eff_addr, eff_addr_nx;
  logic [7:0]  imm_byte;
  logic        no_opnd, ofs_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  opaddr_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .instr_addr(instr_addr), .opnd_hi(opnd_hi), .opnd_lo(opnd_lo), .idx_reg(idx_reg),
    .res_valid(res_valid), .eff_addr(eff_addr), .eff_addr_nx(eff_addr_nx),
    .imm_byte(imm_byte), .no_opnd(no_opnd), .ofs_err(ofs_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    mode = v.mode; instr_addr = v.pc; opnd_hi = v.hi; opnd_lo = v.lo; idx_reg = v.x;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_vec(input vec_t v);
    string r;
    logic [15:0] nx;
    r = $sformatf("R%0d", v.req);
    nx = (v.mode >= 3'd2 && !v.err) ? v.ea + 16'd1 : 16'h0000;
    chk(res_valid == 1'b1, "R2", "res_valid", res_valid, 1);
    chk(eff_addr == v.ea, r, "eff_addr", eff_addr, v.ea);
    chk(ofs_err == v.err, r, "ofs_err", ofs_err, v.err);
    chk(no_opnd == v.none, r, "no_opnd", no_opnd, v.none);
    chk(imm_byte == v.imm, r, "imm_byte", imm_byte, v.imm);
    chk(eff_addr_nx == nx, "R10", "eff_addr_nx", eff_addr_nx, nx);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    vec_t v;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1: outputs zero in reset
    chk({res_valid, eff_addr, eff_addr_nx, imm_byte, no_opnd, ofs_err} == '0,
        "R1", "outputs in reset", eff_addr, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({res_valid, eff_addr, eff_addr_nx, imm_byte, no_opnd, ofs_err} == '0,
        "R1", "outputs after release", eff_addr, 0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      check_vec(TBL[i]);
    end

    // R2 and R11: no strobe, inputs moving, outputs held and valid low
    held = eff_addr;
    @(negedge clk);
    mode = 3'd2; opnd_hi = 8'h5A; opnd_lo = 8'hA5;
    chk(res_valid == 1'b0, "R2", "res_valid after pulse", res_valid, 0);
    @(negedge clk);
    mode = 3'd1;
    @(negedge clk);
    chk(eff_addr == held, "R11", "eff_addr held", eff_addr, held);
    chk(imm_byte == 8'h00, "R11", "imm_byte held", imm_byte, 0);
    chk(res_valid == 1'b0, "R2", "res_valid idle", res_valid, 0);

    // R2: back-to-back strobes keep valid high, second result wins
    @(negedge clk);
    mode = 3'd2; opnd_hi = 8'h12; opnd_lo = 8'h34; req_valid = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b1, "R2", "first of pair", res_valid, 1);
    chk(eff_addr == 16'h1234, "R5", "first of pair addr", eff_addr, 16'h1234);
    mode = 3'd1; opnd_lo = 8'hC3;
    @(negedge clk);
    req_valid = 1'b0;
    chk(res_valid == 1'b1, "R2", "second of pair", res_valid, 1);
    chk(imm_byte == 8'hC3, "R4", "second of pair imm", imm_byte, 8'hC3);
    chk(eff_addr == 16'h0000, "R4", "immediate addr", eff_addr, 0);
    @(negedge clk);
    chk(res_valid == 1'b0, "R2", "pair ended", res_valid, 0);

    // R9: error clears on a following legal indexed access
    v = '{4'd8, 3'd5, 16'h0000, 8'hFF, 8'hEF, 16'h2000, 16'h0000, 1'b1, 1'b0, 8'h00};
    drive(v);
    chk(ofs_err == 1'b1, "R9", "-17 in 5-bit", ofs_err, 1);
    v = '{4'd8, 3'd5, 16'h0000, 8'hFF, 8'hFF, 16'h2000, 16'h1FFF, 1'b0, 1'b0, 8'h00};
    drive(v);
    check_vec(v);

    // R1: reset in the middle of operation clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({res_valid, eff_addr, eff_addr_nx, imm_byte, no_opnd, ofs_err} == '0,
        "R1", "outputs after late reset", eff_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule